// File: doc/BRIEF.md
# Slave Fan-Out Response Multiplexer

This block places one master on a bus whose slaves report completion with a two-bit ready counter, and lets that master reach several such slaves. The master's command is a single-cycle read or write strobe with an address. The top address bits pick a slave, and the strobe goes to that slave alone. The low bits are a word offset inside the slave's range, and they go to every slave unchanged, together with the write data.

Each slave holds its read data in a register of its own. Because of that, one multiplexer stage after the slaves is enough to return the response. The slave index is known in the command cycle but is only needed from the following cycle on. It is therefore stored in a select register, so the wide read-data multiplexer is driven from a flop and not from the address decode. The select register changes only on a command cycle. The slave addressed last keeps driving the master's read data and ready counter until the next command.

The block also reports the read and write pipeline levels the master may use. Each is the smallest level among the attached slaves.

Top module: `slave_fanout_mux`

## Requirements
- R1: `m_rd` is forwarded only on `s_rd[k]`, where k is the master address bits above the low OFS_W bits. Every other slave sees its read strobe low, and no `s_rd` bit is high without `m_rd`.
- R2: `m_wr` is forwarded only on `s_wr[k]`, using the same decode as R1. No `s_wr` bit is high without `m_wr`.
- R3: `s_addr` equals the low OFS_W bits of `m_addr`, and `s_wr_data` equals `m_wr_data`, in the same cycle.
- R4: A cycle with `m_rd` or `m_wr` high loads k into the select register. From the next cycle, `m_rd_data` and `m_rdy_cnt` are the fields of slave k (field i of each flat slave bus is bits i*W upward, where W is the field width).
- R5: In cycles with neither strobe high, the selection holds. Activity on the unselected slaves' responses has no effect on `m_rd_data` or `m_rdy_cnt`.
- R6: `m_rd_pipe` and `m_wr_pipe` are the minimum of the slaves' read and write pipeline levels, respectively.
- R7: During and after reset, the selection is slave 0, so the master sees slave 0's data and ready counter (0 while that slave is idle).
- R8: In the command cycle itself, the response outputs still come from the previously selected slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_addr | input | OFS_W+SEL_W | Master word address; the top SEL_W bits choose the slave |
| m_wr_data | input | DATA_W | Master write data |
| m_rd | input | 1 | Single-cycle read command |
| m_wr | input | 1 | Single-cycle write command |
| m_rd_data | output | DATA_W | Read data of the selected slave |
| m_rdy_cnt | output | 2 | Ready counter of the selected slave |
| m_rd_pipe | output | 2 | Read pipeline level usable by the master |
| m_wr_pipe | output | 2 | Write pipeline level usable by the master |
| s_addr | output | OFS_W | Word offset sent to all slaves |
| s_wr_data | output | DATA_W | Write data sent to all slaves |
| s_rd | output | N_SLV | Per-slave read strobe |
| s_wr | output | N_SLV | Per-slave write strobe |
| s_rd_data | input | N_SLV*DATA_W | Packed read data of all slaves |
| s_rdy_cnt | input | N_SLV*2 | Packed ready counters of all slaves |
| s_rd_pipe | input | N_SLV*2 | Packed read pipeline levels |
| s_wr_pipe | input | N_SLV*2 | Packed write pipeline levels |

## Verification
Two situations are the hardest to reach. One is a command to a new slave issued while the previous slave is still counting down: the response has to switch exactly one cycle after the strobe, not in the strobe cycle. The other is a long idle stretch in which the unselected slaves change their outputs while the selected one does not. The stimulus drives every slave's data and counter with fresh random values on every cycle. It mixes directed back-to-back commands to different slaves with idle runs and a long random stream. A behavioural reference that tracks the addressed slave is compared against all outputs on every cycle.

// File: rtl/slave_fanout_mux.sv
module slave_fanout_mux #(
  parameter int N_SLV  = 4,
  parameter int OFS_W  = 6,
  parameter int DATA_W = 32,
  localparam int SEL_W  = (N_SLV > 1) ? $clog2(N_SLV) : 1,
  localparam int ADDR_W = OFS_W + SEL_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       m_addr,
  input  logic [DATA_W-1:0]       m_wr_data,
  input  logic                    m_rd,
  input  logic                    m_wr,
  output logic [DATA_W-1:0]       m_rd_data,
  output logic [1:0]              m_rdy_cnt,
  output logic [1:0]              m_rd_pipe,
  output logic [1:0]              m_wr_pipe,
  output logic [OFS_W-1:0]        s_addr,
  output logic [DATA_W-1:0]       s_wr_data,
  output logic [N_SLV-1:0]        s_rd,
  output logic [N_SLV-1:0]        s_wr,
  input  logic [N_SLV*DATA_W-1:0] s_rd_data,
  input  logic [N_SLV*2-1:0]      s_rdy_cnt,
  input  logic [N_SLV*2-1:0]      s_rd_pipe,
  input  logic [N_SLV*2-1:0]      s_wr_pipe
);

  logic [SEL_W-1:0] slot;
  logic [SEL_W-1:0] sel_q;

  assign slot      = m_addr[ADDR_W-1:OFS_W];
  assign s_addr    = m_addr[OFS_W-1:0];
  assign s_wr_data = m_wr_data;

  for (genvar i = 0; i < N_SLV; i++) begin : g_strobe
    assign s_rd[i] = m_rd && (slot == SEL_W'(i));
    assign s_wr[i] = m_wr && (slot == SEL_W'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      sel_q <= '0;
    else if (m_rd || m_wr)
      sel_q <= slot;
  end

  always_comb begin
    m_rd_data = '0;
    m_rdy_cnt = '0;
    for (int i = 0; i < N_SLV; i++) begin
      if (sel_q == SEL_W'(i)) begin
        m_rd_data = s_rd_data[i*DATA_W +: DATA_W];
        m_rdy_cnt = s_rdy_cnt[i*2 +: 2];
      end
    end
  end

  always_comb begin
    m_rd_pipe = 2'd3;
    m_wr_pipe = 2'd3;
    for (int i = 0; i < N_SLV; i++) begin
      if (s_rd_pipe[i*2 +: 2] < m_rd_pipe) m_rd_pipe = s_rd_pipe[i*2 +: 2];
      if (s_wr_pipe[i*2 +: 2] < m_wr_pipe) m_wr_pipe = s_wr_pipe[i*2 +: 2];
    end
  end

endmodule

module slave_fanout_mux_chk #(
  parameter int N_SLV  = 4,
  parameter int OFS_W  = 6,
  parameter int SEL_W  = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] m_addr,
  input logic              m_rd,
  input logic              m_wr,
  input logic [N_SLV-1:0]  s_rd,
  input logic [N_SLV-1:0]  s_wr,
  input logic [SEL_W-1:0]  sel_q,
  input logic [1:0]        m_rd_pipe,
  input logic [1:0]        m_wr_pipe,
  input logic [N_SLV*2-1:0] s_rd_pipe,
  input logic [N_SLV*2-1:0] s_wr_pipe
);

  logic [SEL_W-1:0] k;
  assign k = m_addr[ADDR_W-1:OFS_W];

  AST_RD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_rd) == (m_rd ? 1 : 0)); // R1
  AST_RD_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    m_rd |-> s_rd[k]); // R1
  AST_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(s_wr) == (m_wr ? 1 : 0)); // R2
  AST_WR_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |-> s_wr[k]); // R2
  AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd || m_wr) |=> sel_q == $past(k)); // R4
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_rd && !m_wr) |=> $stable(sel_q)); // R5

  for (genvar i = 0; i < N_SLV; i++) begin : g_pipe
    AST_PIPE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (m_rd_pipe <= s_rd_pipe[i*2 +: 2]) && (m_wr_pipe <= s_wr_pipe[i*2 +: 2])); // R6
  end

endmodule

bind slave_fanout_mux slave_fanout_mux_chk #(
  .N_SLV(N_SLV), .OFS_W(OFS_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_rd(m_rd), .m_wr(m_wr),
  .s_rd(s_rd), .s_wr(s_wr), .sel_q(sel_q),
  .m_rd_pipe(m_rd_pipe), .m_wr_pipe(m_wr_pipe),
  .s_rd_pipe(s_rd_pipe), .s_wr_pipe(s_wr_pipe)
);

// File: tb/slave_fanout_mux_tb.sv
module slave_fanout_mux_tb;
  localparam int N = 4;
  localparam int OW = 6;
  localparam int DW = 32;
  localparam int AW = OW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wr_data = '0;
  logic m_rd = 1'b0, m_wr = 1'b0;
  logic [DW-1:0] m_rd_data;
  logic [1:0] m_rdy_cnt, m_rd_pipe, m_wr_pipe;
  logic [OW-1:0] s_addr;
  logic [DW-1:0] s_wr_data;
  logic [N-1:0] s_rd, s_wr;
  logic [N*DW-1:0] s_rd_data;
  logic [N*2-1:0] s_rdy_cnt, s_rd_pipe, s_wr_pipe;

  logic [DW-1:0] sd [N];
  logic [1:0] sc [N], srp [N], swp [N];

  always_comb begin
    for (int i = 0; i < N; i++) begin
      s_rd_data[i*DW +: DW] = sd[i];
      s_rdy_cnt[i*2 +: 2]   = sc[i];
      s_rd_pipe[i*2 +: 2]   = srp[i];
      s_wr_pipe[i*2 +: 2]   = swp[i];
    end
  end

  slave_fanout_mux #(.N_SLV(N), .OFS_W(OW), .DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr_data(m_wr_data),
    .m_rd(m_rd), .m_wr(m_wr), .m_rd_data(m_rd_data), .m_rdy_cnt(m_rdy_cnt),
    .m_rd_pipe(m_rd_pipe), .m_wr_pipe(m_wr_pipe), .s_addr(s_addr),
    .s_wr_data(s_wr_data), .s_rd(s_rd), .s_wr(s_wr), .s_rd_data(s_rd_data),
    .s_rdy_cnt(s_rdy_cnt), .s_rd_pipe(s_rd_pipe), .s_wr_pipe(s_wr_pipe)
  );

  always #2 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int ref_sel = 0;

  always @(posedge clk) begin
    if (!rst_n) ref_sel = 0;
    else if (m_rd || m_wr) ref_sel = int'(m_addr[AW-1:OW]);
  end

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    int k;
    logic [N-1:0] er, ew;
    logic [1:0] mr, mw;
    k = int'(m_addr[AW-1:OW]);
    er = '0; ew = '0;
    if (m_rd) er[k] = 1'b1;
    if (m_wr) ew[k] = 1'b1;
    mr = 2'd3; mw = 2'd3;
    for (int i = 0; i < N; i++) begin
      if (srp[i] < mr) mr = srp[i];
      if (swp[i] < mw) mw = swp[i];
    end
    chk("R1 s_rd", DW'(s_rd), DW'(er));
    chk("R2 s_wr", DW'(s_wr), DW'(ew));
    chk("R3 s_addr", DW'(s_addr), DW'(m_addr[OW-1:0]));
    chk("R3 s_wr_data", s_wr_data, m_wr_data);
    chk("R4 R5 R7 R8 m_rd_data", m_rd_data, sd[ref_sel]);
    chk("R4 R5 R7 R8 m_rdy_cnt", DW'(m_rdy_cnt), DW'(sc[ref_sel]));
    chk("R6 m_rd_pipe", DW'(m_rd_pipe), DW'(mr));
    chk("R6 m_wr_pipe", DW'(m_wr_pipe), DW'(mw));
  endtask

  task automatic cyc(input logic rd, input logic wr, input int slv, input bit scramble);
    @(negedge clk);
    m_rd = rd;
    m_wr = wr;
    m_addr = {2'(slv), 6'($urandom)};
    m_wr_data = $urandom;
    if (scramble) begin
      for (int i = 0; i < N; i++) begin
        sd[i] = $urandom;
        sc[i] = 2'($urandom);
      end
      if (($urandom % 8) == 0)
        for (int i = 0; i < N; i++) begin
          srp[i] = 2'($urandom);
          swp[i] = 2'($urandom);
        end
    end
    #1 compare_all();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      sd[i] = 32'hA000_0000 + i; sc[i] = 2'd0; srp[i] = 2'd3; swp[i] = 2'd2;
    end
    srp[2] = 2'd1;
    repeat (3) @(negedge clk);
    #1;
    chk("R7 reset rd_data slave0", m_rd_data, 32'hA000_0000);
    chk("R7 reset rdy_cnt", DW'(m_rdy_cnt), 32'd0);
    chk("R6 reset pipe min", DW'(m_rd_pipe), 32'd1);
    @(negedge clk) rst_n = 1'b1;
    cyc(1, 0, 2, 1);
    for (int j = 0; j < 6; j++) cyc(0, 0, j % N, 1);
    cyc(0, 1, 3, 1);
    cyc(1, 0, 1, 1);
    cyc(1, 0, 0, 1);
    cyc(0, 1, 2, 1);
    for (int j = 0; j < 4; j++) cyc(0, 0, 1, 1);
    for (int j = 0; j < 2000; j++) begin
      int r;
      r = int'($urandom % 10);
      cyc(r < 3, r >= 3 && r < 5, int'($urandom % N), 1);
    end
    @(negedge clk) rst_n = 1'b0;
    cyc(1, 0, 3, 1);
    cyc(0, 0, 3, 1);
    @(negedge clk) rst_n = 1'b1;
    cyc(0, 0, 2, 1);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule